// File: doc/BRIEF.md
# Multi-Input Wake-Up Controller

This block watches a bank of 64 asynchronous wake-up sources and turns edges on them into a wake request for the power manager. It also drives eight interrupt request lines. It runs on the slow clock, so it keeps working while the main clock is stopped.

Each source has its own settings:
- an enable bit;
- a trigger-edge bit (rising or falling);
- a sticky pending bit;
- a three-bit selector that places it on one of the eight interrupt lines.

Each source passes through a two-flop synchroniser before its edge is detected. A detected edge sets the pending bit of that source. Software clears the bit by writing a one to it through the register port.

After reset, a small arming state machine holds off edge detection until the synchronisers carry the real input levels. This stops the levels already present at reset from showing up as events. The machine has four states:
- `ARM_FILL0`, `ARM_FILL1` and `ARM_FILL2` step one to the next on each clock.
- `ARM_FILL2` goes to `ARM_RUN` on the following clock.
- `ARM_RUN` holds until reset.

Edge detection is active only in `ARM_RUN`.

Top module: `wkup_hub`

## Requirements
- R1: After reset, every enable, edge, pending and route field reads 0, and `irq_o` and `wake_o` are low.
- R2: An edge bit of 0 makes a source trigger on a 0-to-1 transition only. An edge bit of 1 makes it trigger on a 1-to-0 transition only. A transition of the other kind leaves the pending bit unchanged.
- R3: Suppose a source level changes before clock edge n and the arming machine is in `ARM_RUN`. Then the pending bit is still clear after edges n and n+1, and is set after edge n+2.
- R4: A pending bit stays set until a register write puts a 1 in its position. Writing 0 leaves it set. If an edge and a clearing write land on the same clock, the bit ends up set.
- R5: A pending bit is set whether or not the source is enabled. A disabled pending source drives no output. Enabling it later raises its outputs without a new edge.
- R6: Interrupt line j is high exactly when some source is pending, enabled and has route selector value j.
- R7: `wake_o` is high exactly when some source is both pending and enabled, whatever its route. It therefore equals the OR of all interrupt lines.
- R8: The register map works as follows:
  - `reg_addr[4:3]` selects the group: 0 enable, 1 edge, 2 pending, 3 route. `reg_addr[2:0]` selects the word.
  - Enable, edge and pending words 0 and 1 cover sources 32w+b at bit b.
  - Route word w holds the selector of source 8w+j in bits [4j+2:4j]. Bit 4j+3 reads 0.
  - Enable, edge and pending words 2 to 7 read 0, and writes to them change nothing.
  - Reads are combinational from `reg_addr`. Writes take effect on the clock where `reg_wr` is high.
- R9: Levels present at the first clock edge after reset release set no pending bit. Pending bits stay clear until the machine reaches `ARM_RUN`, and it stays there.
- R10: Changing an edge bit while the source level is steady sets no pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wk_in | input | 64 | Asynchronous wake-up sources |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address: group in [4:3], word in [2:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | 8 | Interrupt request lines |
| wake_o | output | 1 | Wake request to the power manager |

## Verification
The bench targets the following corner cases:
- **Exact three-edge latency.** An off-by-one synchroniser would raise the wake output one clock early or late.
- **Edge and clearing write on the same clock.** A design that lets the clear win would silently lose a wake event.
- **Inputs held high through reset.** Skipping the arming states would produce spurious pending bits at start-up.
- **Polarity rewrites on a steady input.** A level-based detector would falsely trigger here.
- **Writes to unused words.** Bad decoding would corrupt the enable words.
- **Pending but disabled sources.** These must stay silent until enabled, then appear on the right line.

A long random phase compares every output and every read against a behavioural model on each clock.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    typedef enum logic [1:0] {
        GRP_EN    = 2'd0,
        GRP_EDGE  = 2'd1,
        GRP_PEND  = 2'd2,
        GRP_ROUTE = 2'd3
    } reg_grp_e;

    typedef enum logic [1:0] {
        ARM_FILL0 = 2'd0,
        ARM_FILL1 = 2'd1,
        ARM_FILL2 = 2'd2,
        ARM_RUN   = 2'd3
    } arm_state_e;

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
    parameter int NCH = 64
) (
    input  logic           clk_slow,
    input  logic           rst_n,
    input  logic [NCH-1:0] async_in,
    output logic [NCH-1:0] rise_o,
    output logic [NCH-1:0] fall_o
);
    logic [NCH-1:0] meta_q;
    logic [NCH-1:0] stable_q;
    logic [NCH-1:0] last_q;

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
            last_q   <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
            last_q   <= stable_q;
        end
    end

    always_comb begin
        rise_o = stable_q & ~last_q;
        fall_o = ~stable_q & last_q;
    end
endmodule

// File: rtl/wkup_arm_fsm.sv
module wkup_arm_fsm
    import wkup_pkg::*;
(
    input  logic clk_slow,
    input  logic rst_n,
    output logic run_o
);
    arm_state_e state_q;
    arm_state_e state_d;

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_FILL0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_FILL0: state_d = ARM_FILL1;
            ARM_FILL1: state_d = ARM_FILL2;
            ARM_FILL2: state_d = ARM_RUN;
            ARM_RUN:   state_d = ARM_RUN;
        endcase
    end

    always_comb begin
        run_o = 1'b0;
        unique case (state_q)
            ARM_FILL0, ARM_FILL1, ARM_FILL2: run_o = 1'b0;
            ARM_RUN:                         run_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wkup_regs.sv
module wkup_regs
    import wkup_pkg::*;
#(
    parameter int NCH  = 64,
    parameter int NIRQ = 8,
    parameter int DW   = 32,
    parameter int AW   = 5
) (
    input  logic                          clk_slow,
    input  logic                          rst_n,
    input  logic                          run,
    input  logic [NCH-1:0]                rise,
    input  logic [NCH-1:0]                fall,
    input  logic                          reg_wr,
    input  logic [AW-1:0]                 reg_addr,
    input  logic [DW-1:0]                 reg_wdata,
    output logic [DW-1:0]                 reg_rdata,
    output logic [NCH-1:0]                en_o,
    output logic [NCH-1:0]                pend_o,
    output logic [NCH*$clog2(NIRQ)-1:0]   route_o
);
    localparam int SELW = $clog2(NIRQ);
    localparam int NIB  = SELW + 1;
    localparam int RPW  = DW / NIB;
    localparam int NW   = NCH / DW;
    localparam int NRW  = NCH / RPW;
    localparam int IDXW = AW - 2;

    reg_grp_e              grp;
    logic [IDXW-1:0]       idx;
    logic [NCH-1:0]        en_q;
    logic [NCH-1:0]        fall_sel_q;
    logic [NCH-1:0]        pend_q;
    logic [NCH*SELW-1:0]   route_q;
    logic [NCH-1:0]        event_w;
    logic [NCH-1:0]        clear_w;

    assign grp = reg_grp_e'(reg_addr[AW-1:AW-2]);
    assign idx = reg_addr[IDXW-1:0];

    always_comb begin
        event_w = run ? ((rise & ~fall_sel_q) | (fall & fall_sel_q)) : '0;
        clear_w = '0;
        if (reg_wr && grp == GRP_PEND) begin
            for (int w = 0; w < NW; w++) begin
                if (idx == IDXW'(w)) begin
                    clear_w[w*DW +: DW] = reg_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= '0;
            fall_sel_q <= '0;
            pend_q     <= '0;
            route_q    <= '0;
        end else begin
            for (int w = 0; w < NW; w++) begin
                if (reg_wr && grp == GRP_EN && idx == IDXW'(w)) begin
                    en_q[w*DW +: DW] <= reg_wdata;
                end
                if (reg_wr && grp == GRP_EDGE && idx == IDXW'(w)) begin
                    fall_sel_q[w*DW +: DW] <= reg_wdata;
                end
            end
            for (int w = 0; w < NRW; w++) begin
                if (reg_wr && grp == GRP_ROUTE && idx == IDXW'(w)) begin
                    for (int j = 0; j < RPW; j++) begin
                        route_q[(w*RPW+j)*SELW +: SELW] <= reg_wdata[j*NIB +: SELW];
                    end
                end
            end
            pend_q <= (pend_q & ~clear_w) | event_w;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (grp)
            GRP_EN: begin
                for (int w = 0; w < NW; w++) begin
                    if (idx == IDXW'(w)) reg_rdata = en_q[w*DW +: DW];
                end
            end
            GRP_EDGE: begin
                for (int w = 0; w < NW; w++) begin
                    if (idx == IDXW'(w)) reg_rdata = fall_sel_q[w*DW +: DW];
                end
            end
            GRP_PEND: begin
                for (int w = 0; w < NW; w++) begin
                    if (idx == IDXW'(w)) reg_rdata = pend_q[w*DW +: DW];
                end
            end
            GRP_ROUTE: begin
                for (int w = 0; w < NRW; w++) begin
                    if (idx == IDXW'(w)) begin
                        for (int j = 0; j < RPW; j++) begin
                            reg_rdata[j*NIB +: SELW] = route_q[(w*RPW+j)*SELW +: SELW];
                        end
                    end
                end
            end
        endcase
    end

    assign en_o    = en_q;
    assign pend_o  = pend_q;
    assign route_o = route_q;
endmodule

// File: rtl/wkup_route.sv
module wkup_route #(
    parameter int NCH  = 64,
    parameter int NIRQ = 8
) (
    input  logic [NCH-1:0]              en,
    input  logic [NCH-1:0]              pend,
    input  logic [NCH*$clog2(NIRQ)-1:0] route,
    output logic [NIRQ-1:0]             irq_o,
    output logic                        wake_o
);
    localparam int SELW = $clog2(NIRQ);

    logic [NCH-1:0] active;

    assign active = en & pend;
    assign wake_o = |active;

    for (genvar j = 0; j < NIRQ; j++) begin : g_line
        logic [NCH-1:0] hit;
        always_comb begin
            for (int i = 0; i < NCH; i++) begin
                hit[i] = active[i] && (route[i*SELW +: SELW] == SELW'(j));
            end
        end
        assign irq_o[j] = |hit;
    end
endmodule

// File: rtl/wkup_hub.sv
module wkup_hub #(
    parameter int NCH  = 64,
    parameter int NIRQ = 8,
    parameter int DW   = 32,
    parameter int AW   = 5
) (
    input  logic            clk_slow,
    input  logic            rst_n,
    input  logic [NCH-1:0]  wk_in,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic [NIRQ-1:0] irq_o,
    output logic            wake_o
);
    localparam int SELW = $clog2(NIRQ);

    logic [NCH-1:0]      rise_w;
    logic [NCH-1:0]      fall_w;
    logic                run_w;
    logic [NCH-1:0]      en_w;
    logic [NCH-1:0]      pend_w;
    logic [NCH*SELW-1:0] route_w;

    wkup_sync #(.NCH(NCH)) u_sync (
        .clk_slow (clk_slow),
        .rst_n    (rst_n),
        .async_in (wk_in),
        .rise_o   (rise_w),
        .fall_o   (fall_w)
    );

    wkup_arm_fsm u_arm (
        .clk_slow (clk_slow),
        .rst_n    (rst_n),
        .run_o    (run_w)
    );

    wkup_regs #(.NCH(NCH), .NIRQ(NIRQ), .DW(DW), .AW(AW)) u_regs (
        .clk_slow  (clk_slow),
        .rst_n     (rst_n),
        .run       (run_w),
        .rise      (rise_w),
        .fall      (fall_w),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en_o      (en_w),
        .pend_o    (pend_w),
        .route_o   (route_w)
    );

    wkup_route #(.NCH(NCH), .NIRQ(NIRQ)) u_route (
        .en     (en_w),
        .pend   (pend_w),
        .route  (route_w),
        .irq_o  (irq_o),
        .wake_o (wake_o)
    );
endmodule

// File: rtl/wkup_hub_chk.sv
module wkup_hub_chk #(
    parameter int NCH  = 64,
    parameter int NIRQ = 8,
    parameter int AW   = 5
) (
    input logic            clk_slow,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic [NIRQ-1:0] irq_o,
    input logic            wake_o,
    input logic [NCH-1:0]  pend,
    input logic [NCH-1:0]  en,
    input logic            run
);
    // R7: wake equals OR of the interrupt lines
    p_wake_matches_lines_r7: assert property (@(posedge clk_slow) disable iff (!rst_n)
        wake_o == (|irq_o));

    // R6: no line without an enabled source
    p_lines_need_enable_r6: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (en == '0) |-> (irq_o == '0));

    // R9: nothing pending before arming completes
    p_quiet_until_armed_r9: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !run |-> (pend == '0));

    // R9: once armed, stays armed
    p_run_holds_r9: assert property (@(posedge clk_slow) disable iff (!rst_n)
        run |=> run);

    // R4: pending bits only drop through a write to the pending group
    p_pend_sticky_r4: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !(reg_wr && reg_addr[AW-1:AW-2] == 2'd2) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

bind wkup_hub wkup_hub_chk #(.NCH(NCH), .NIRQ(NIRQ), .AW(AW)) u_chk (
    .clk_slow (clk_slow),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .irq_o    (irq_o),
    .wake_o   (wake_o),
    .pend     (pend_w),
    .en       (en_w),
    .run      (run_w)
);

// File: tb/wkup_hub_tb.sv
module wkup_hub_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] wk_in = 64'hF0F0_F0F0_F0F0_F0F0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_o;
    logic        wake_o;

    int checks = 0;
    int errors = 0;

    wkup_hub u_dut (
        .clk_slow (clk),
        .rst_n    (rst_n),
        .wk_in    (wk_in),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_o    (irq_o),
        .wake_o   (wake_o)
    );

    always #10 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit [63:0] m_en, m_fall, m_pend;
    bit [63:0] h1, h2, h3;      // input seen 1, 2, 3 edges ago
    int        m_rt[64];
    int        ecnt;

    always @(posedge clk) begin
        bit [63:0] ev;
        bit [63:0] clr;
        if (!rst_n) begin
            m_en = '0; m_fall = '0; m_pend = '0; ecnt = 0;
            for (int i = 0; i < 64; i++) m_rt[i] = 0;
        end else begin
            ecnt++;
            ev = '0;
            clr = '0;
            if (ecnt >= 4) begin
                for (int i = 0; i < 64; i++) begin
                    if (h2[i] != h3[i]) ev[i] = m_fall[i] ? !h2[i] : h2[i];
                end
            end
            if (reg_wr) begin
                int x;
                x = int'(reg_addr[2:0]);
                case (reg_addr[4:3])
                    2'd0: if (x < 2) m_en[x*32 +: 32] = reg_wdata;
                    2'd1: if (x < 2) m_fall[x*32 +: 32] = reg_wdata;
                    2'd2: if (x < 2) clr[x*32 +: 32] = reg_wdata;
                    default: for (int j = 0; j < 8; j++) m_rt[x*8+j] = int'((reg_wdata >> (4*j)) & 32'h7);
                endcase
            end
            m_pend = (m_pend & ~clr) | ev;
            h3 = h2; h2 = h1; h1 = wk_in;
        end
    end

    function automatic logic [7:0] m_irq();
        logic [7:0] r = '0;
        for (int i = 0; i < 64; i++)
            if (m_pend[i] && m_en[i]) r[m_rt[i]] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        int x = int'(a[2:0]);
        logic [31:0] r = '0;
        case (a[4:3])
            2'd0: if (x < 2) r = m_en[x*32 +: 32];
            2'd1: if (x < 2) r = m_fall[x*32 +: 32];
            2'd2: if (x < 2) r = m_pend[x*32 +: 32];
            default: for (int j = 0; j < 8; j++) r[4*j +: 3] = 3'(m_rt[x*8+j]);
        endcase
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison, sampled well after the edge
    always @(posedge clk) begin
        #8;
        chk("R6 irq lines vs model", 64'(irq_o), 64'(m_irq()));
        chk("R7 wake vs model", 64'(wake_o), 64'(m_irq() != 8'h0));
        chk("R8 read data vs model", 64'(reg_rdata), 64'(m_read(reg_addr)));
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] route_word(input int w);
        logic [31:0] r = '0;
        for (int j = 0; j < 8; j++) r[4*j +: 4] = 4'((j + w) % 8);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired, run hung (all requirements)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        tick(3);
        #1;
        chk("R1 irq low in reset", 64'(irq_o), 64'h0);
        chk("R1 wake low in reset", 64'(wake_o), 64'h0);
        @(negedge clk); rst_n = 1'b1;
        tick(6);
        rd(5'b10000, v); chk("R9 no pending from reset levels w0", 64'(v), 64'h0);
        rd(5'b10001, v); chk("R9 no pending from reset levels w1", 64'(v), 64'h0);
        rd(5'b11011, v); chk("R1 route word reset", 64'(v), 64'h0);
        rd(5'b00000, v); chk("R1 enable word reset", 64'(v), 64'h0);

        // configuration
        wr(5'b00000, 32'hFFFF_FF7F);     // source 7 disabled
        wr(5'b00001, 32'hFFFF_FFFF);
        wr(5'b01001, 32'hFFFF_FFFF);     // sources 32..63 falling
        for (int w = 0; w < 8; w++) wr(5'(5'b11000 | w), route_word(w));
        rd(5'b11010, v); chk("R8 route word 2 readback", 64'(v), 64'(route_word(2)));
        wr(5'b11111, 32'hFFFF_FFFF);
        rd(5'b11111, v); chk("R8 route spare bits read 0", 64'(v), 64'h7777_7777);
        wr(5'b11111, route_word(7));

        // R3 latency on source 3 (rising, line 3)
        @(negedge clk); wk_in[3] = 1'b1; #1;
        chk("R3 wake before edge n", 64'(wake_o), 64'h0);
        @(negedge clk); #1 chk("R3 wake after edge n", 64'(wake_o), 64'h0);
        @(negedge clk); #1 chk("R3 wake after edge n+1", 64'(wake_o), 64'h0);
        @(negedge clk); #1 chk("R3 wake after edge n+2", 64'(wake_o), 64'h1);
        chk("R6 source 3 on line 3", 64'(irq_o), 64'h08);

        // R2 polarity: source 44 falls (falling cfg), source 40 rises (falling cfg)
        @(negedge clk); wk_in[44] = 1'b0; wk_in[40] = 1'b1;
        tick(3);
        rd(5'b10001, v); chk("R2 only selected edge sets pending", 64'(v), 64'h0000_1000);
        #1 chk("R6 sources 3 and 44 on lines 3 and 1", 64'(irq_o), 64'h0A);

        // R4 write-one-to-clear
        wr(5'b10000, 32'h0);
        rd(5'b10000, v); chk("R4 writing zero keeps pending", 64'(v), 64'h8);
        wr(5'b10000, 32'h8);
        rd(5'b10000, v); chk("R4 writing one clears pending", 64'(v), 64'h0);
        wr(5'b10001, 32'h1000);
        #1 chk("R7 wake drops when nothing pending", 64'(wake_o), 64'h0);

        // R4 set wins over clear on the same edge
        @(negedge clk); wk_in[3] = 1'b0;
        tick(3);
        @(negedge clk); wk_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 5'b10000; reg_wdata = 32'h8;
        @(negedge clk); reg_wr = 1'b0;
        rd(5'b10000, v); chk("R4 edge beats clear", 64'(v), 64'h8);
        wr(5'b10000, 32'h8);

        // R5 disabled source 7 still latches, outputs only after enable
        @(negedge clk); wk_in[7] = 1'b0;
        tick(3);
        @(negedge clk); wk_in[7] = 1'b1;
        tick(3);
        rd(5'b10000, v); chk("R5 disabled source pends", 64'(v), 64'h80);
        #1 chk("R5 disabled source no wake", 64'(wake_o), 64'h0);
        wr(5'b00000, 32'hFFFF_FFFF);
        #1 chk("R5 enable raises wake", 64'(wake_o), 64'h1);
        chk("R5 enable raises line 7", 64'(irq_o), 64'h80);
        wr(5'b10000, 32'h80);

        // R10 polarity rewrite on steady level
        wr(5'b01000, 32'h80);
        tick(3);
        rd(5'b10000, v); chk("R10 polarity change sets nothing", 64'(v), 64'h0);
        wr(5'b01000, 32'h0);

        // R8 unused words
        wr(5'b00101, 32'h0);
        rd(5'b00101, v); chk("R8 unused word reads 0", 64'(v), 64'h0);
        rd(5'b00000, v); chk("R8 enable w0 untouched", 64'(v), 64'hFFFF_FFFF);
        rd(5'b00001, v); chk("R8 enable w1 untouched", 64'(v), 64'hFFFF_FFFF);

        // random phase against the model (R2 R4 R6 R7 R8)
        for (int c = 0; c < 2500; c++) begin
            @(negedge clk);
            wk_in = wk_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            reg_addr  = 5'($urandom);
            reg_wdata = $urandom;
            reg_wr    = (($urandom % 6) == 0);
        end
        @(negedge clk); reg_wr = 1'b0;
        tick(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule